// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block raises an interrupt after a programmed number of video lines in a cartridge memory mapper. The video bus toggles address line A12 once per rendered line. The block brings that asynchronous line into the CPU bus clock domain through a two-flop synchroniser and turns each rising edge into a single-cycle counting event. Each event updates an 8-bit down-counter. When the count is exhausted, the counter reloads from a latch.

When the count runs out, the block pulls the active-low interrupt output low. The output stays low until software acknowledges it. Software controls the block through four register selects, sampled on the CPU bus clock:

- write the reload latch;
- request a reload;
- disable and acknowledge;
- enable.

A mode input chooses between two interrupt rules. In the zero-equal rule, the interrupt fires on every event that leaves the count at zero. In the decrement-to-zero rule, it fires only when the count reaches zero from a nonzero value, or from a pending reload request.

Top module: `line_irq_unit`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, `irq_n` is high, the counter and latch are zero, interrupts are disabled and no reload request is pending.
- R2: `a12_in` passes through two synchronising flops. If `a12_in` is first sampled high at edge k, the counting event acts at edge k+2, so `irq_n` can fall only after edge k+2. A level held high produces exactly one event.
- R3: On each event, if the count is zero or a reload request is pending, the count takes the latch value and the request clears. Otherwise the count decrements by one.
- R4: With `alt_mode`=0, an event whose resulting count is zero raises the interrupt if it is enabled. With a latch of zero, this gives one interrupt per line.
- R5: With `alt_mode`=1, an event raises the interrupt only if the resulting count is zero and, before the event, the count was nonzero or a reload was pending. With a latch of zero this gives a single interrupt, and each reload write then gives exactly one more.
- R6: Once low, `irq_n` stays low for any number of cycles and across further events, until a disable write.
- R7: A write with `wr_sel`=3'b110 sets `irq_n` high at the next edge and clears the enable flag. This is the only acknowledge.
- R8: A write with `wr_sel`=3'b111 sets the enable flag but never lowers `irq_n` by itself, even when the count is zero. Only a later event can raise the interrupt.
- R9: While interrupts are disabled, events still update the count, and no interrupt is raised.
- R10: A write with `wr_sel`=3'b100 stores `wr_data` in the latch. A write with `wr_sel`=3'b101 clears the count to zero and sets the reload request. Writes take effect only when `wr_en` is high, and selects 3'b000 to 3'b011 change nothing.
- R11: When a write and an event fall in the same cycle:
  - the event uses the old latch and the old enable flag;
  - a reload write overrides the event's count update;
  - a disable write overrides an interrupt raised by that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a12_in | input | 1 | Asynchronous video-bus address line A12 |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_sel | input | 3 | Register select (3'b100 to 3'b111 used) |
| wr_data | input | 8 | Write data, used by the latch write |
| alt_mode | input | 1 | 0 = zero-equal rule, 1 = decrement-to-zero rule |
| irq_n | output | 1 | Active-low interrupt, held until acknowledged |

## Verification
Counter state is hidden and shows only through `irq_n`. A wrong count or a stale reload request therefore appears as an interrupt one or more lines early or late. It becomes visible at the event that would have brought the count to zero, which can be up to 256 lines after the fault. A corrupted enable flag or interrupt latch shows on the next edge, or at the next event, as `irq_n` in the wrong state.

The bench compares `irq_n` on every cycle against a behavioural model. It also checks exact lines and edges in directed sequences: latency, hold, acknowledge, each mode's one-shot behaviour, and same-cycle collisions.

// File: rtl/line_irq_pkg.sv
// Shared register-select codes for the scanline interrupt counter.
package line_irq_pkg;
    typedef enum logic [2:0] {
        SEL_LATCH   = 3'b100,
        SEL_RELOAD  = 3'b101,
        SEL_DISABLE = 3'b110,
        SEL_ENABLE  = 3'b111
    } reg_sel_e;
endpackage

// File: rtl/a12_edge_sync.sv
// Synchronises the asynchronous line-clock input into the CPU bus clock
// domain and emits a one-cycle pulse per rising edge.
// Assumes the input stays at each level for at least one clock period.
module a12_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic rise_evt
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] stage_q;

    // First synchroniser flop samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= line_async;
    end

    // Remaining synchroniser flops plus one history flop for edge detection.
    for (genvar i = 1; i <= LAST; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= 1'b0;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    // A rising edge is a synchronised high after a synchronised low.
    always_comb rise_evt = stage_q[LAST-1] & ~stage_q[LAST];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> !rise_evt); // R2
endmodule

// File: rtl/line_down_counter.sv
// Reloadable line down-counter.
// - Holds the reload latch, the count and the reload request.
// - Flags the counting events that qualify for an interrupt under the
//   selected mode.
// Assumes that the latch and reload writes are single-cycle strobes.
module line_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             latch_wr,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             alt_mode,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] latch_q, cnt_q, cnt_nx;
    logic             req_q, req_nx;

    // Next count, next request and interrupt qualification for this cycle.
    always_comb begin
        cnt_nx = cnt_q;
        req_nx = req_q;
        fire   = 1'b0;
        if (evt) begin
            if (cnt_q == ZERO || req_q) begin
                cnt_nx = latch_q;
                req_nx = 1'b0;
            end else begin
                cnt_nx = cnt_q - ONE;
            end
            if (alt_mode) fire = (cnt_nx == ZERO) && (cnt_q != ZERO || req_q);
            else          fire = (cnt_nx == ZERO);
        end
        if (reload_wr) begin
            cnt_nx = ZERO;
            req_nx = 1'b1;
        end
    end

    // Count and reload-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            req_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            req_q <= req_nx;
        end
    end

    // Reload latch register.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= ZERO;
        else if (latch_wr) latch_q <= wr_data;
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        evt && cnt_q != ZERO && !req_q && !reload_wr
            |=> cnt_q == $past(cnt_q) - ONE); // R3
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        evt && (cnt_q == ZERO || req_q) && !reload_wr
            |=> cnt_q == $past(latch_q) && !req_q); // R3
    AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> cnt_q == ZERO && req_q); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt && !reload_wr |=> $stable(cnt_q) && $stable(req_q)); // R3
endmodule

// File: rtl/irq_hold_flag.sv
// Enable flag and latched interrupt.
// - A qualified event sets the interrupt only while enabled.
// - A disable write clears both the interrupt and the enable flag.
// Assumes that the event qualification arrives as a single-cycle strobe.
module irq_hold_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic en_wr,
    input  logic dis_wr,
    output logic irq_n
);
    logic en_q, pend_q;

    // Enable flag: set by the enable write, cleared by the disable write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (dis_wr) en_q <= 1'b0;
        else if (en_wr)  en_q <= 1'b1;
    end

    // Interrupt latch: set by a qualified, enabled event; cleared only by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend_q <= 1'b0;
        else if (dis_wr)         pend_q <= 1'b0;
        else if (fire && en_q)   pend_q <= 1'b1;
    end

    // Drive the active-low interrupt output.
    always_comb irq_n = ~pend_q;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !dis_wr |=> pend_q); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> !pend_q && !en_q); // R7
    AST_NO_WRITE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q && !fire |=> !pend_q); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q && !en_q |=> !pend_q); // R9
endmodule

// File: rtl/line_irq_unit.sv
// Top level of the scanline interrupt counter.
// - Decodes the four register writes.
// - Connects the synchroniser, the counter and the interrupt latch.
// Assumes that clk is the CPU bus clock and runs much faster than line edges.
module line_irq_unit #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a12_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             alt_mode,
    output logic             irq_n
);
    import line_irq_pkg::*;

    logic evt, fire;
    logic latch_wr, reload_wr, dis_wr, en_wr;

    // Register-select decode; other selects are ignored here.
    always_comb begin
        latch_wr  = wr_en && (wr_sel == SEL_LATCH);
        reload_wr = wr_en && (wr_sel == SEL_RELOAD);
        dis_wr    = wr_en && (wr_sel == SEL_DISABLE);
        en_wr     = wr_en && (wr_sel == SEL_ENABLE);
    end

    a12_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (a12_in),
        .rise_evt   (evt)
    );

    line_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .latch_wr  (latch_wr),
        .reload_wr (reload_wr),
        .wr_data   (wr_data),
        .alt_mode  (alt_mode),
        .fire      (fire)
    );

    irq_hold_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .en_wr  (en_wr),
        .dis_wr (dis_wr),
        .irq_n  (irq_n)
    );

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(evt)); // R8
endmodule

// File: tb/sim_line_irq_unit.sv
`timescale 1ns/1ps
module sim_line_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a12_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'b000;
    logic [7:0] wr_data = 8'h00;
    logic       alt_mode = 1'b0;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit model_live = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    line_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .a12_in(a12_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .alt_mode(alt_mode), .irq_n(irq_n)
    );

    // Behavioural reference: history of input samples plus integer state.
    bit hist[$] = '{0, 0, 0};
    int m_cnt = 0, m_latch = 0;
    bit m_req = 0, m_en = 0, m_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_latch = 0; m_req = 0; m_en = 0; m_irq = 0;
            hist = '{0, 0, 0};
        end else begin
            bit ev, fire;
            int ncnt, nlatch;
            bit nreq, nen, nirq;
            ev = hist[1] && !hist[2];
            fire = 0; ncnt = m_cnt; nreq = m_req; nlatch = m_latch; nen = m_en;
            if (ev) begin
                if (m_cnt == 0 || m_req) begin ncnt = m_latch; nreq = 0; end
                else ncnt = m_cnt - 1;
                if (alt_mode) fire = (ncnt == 0) && (m_cnt != 0 || m_req);
                else          fire = (ncnt == 0);
            end
            nirq = m_irq || (fire && m_en);
            if (wr_en) begin
                case (wr_sel)
                    3'b100: nlatch = int'(wr_data);
                    3'b101: begin ncnt = 0; nreq = 1; end
                    3'b110: begin nen = 0; nirq = 0; end
                    3'b111: nen = 1;
                    default: ;
                endcase
            end
            m_cnt = ncnt; m_req = nreq; m_latch = nlatch; m_en = nen; m_irq = nirq;
            hist.push_front(a12_in);
            void'(hist.pop_back());
        end
        model_live = 1'b1;
    end

    // Per-cycle comparison against the model (covers R11 collisions in the random phase).
    always @(negedge clk) begin
        if (model_live && !finished) begin
            n_chk++;
            if (irq_n !== !m_irq) begin
                n_fail++;
                $display("FAIL R11 model: irq_n=%b expected %b at %0t", irq_n, !m_irq, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 3'b000; wr_data = 8'h00;
    endtask

    task automatic line();
        a12_in = 1'b1; step(4);
        a12_in = 1'b0; step(4);
    endtask

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (irq_n !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_n=%b expected %b at %0t", req, irq_n, exp, $time);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        step(3); rst_n = 1'b1; step(1);
        chk("R1", 1'b1);

        // Zero-equal mode, latch 2: third line fires, with two-flop latency.
        alt_mode = 1'b0;
        wr(3'b100, 8'd2); wr(3'b111, 8'd0);
        line(); line();
        chk("R3", 1'b1);
        a12_in = 1'b1; step(2);
        chk("R2", 1'b1);
        step(1);
        chk("R2", 1'b0);
        a12_in = 1'b0; step(3);
        chk("R4", 1'b0);
        step(50);
        chk("R6", 1'b0);
        wr(3'b110, 8'd0);
        chk("R7", 1'b1);
        wr(3'b111, 8'd0); step(20);
        chk("R8", 1'b1);
        line();
        chk("R3", 1'b1);

        // Zero-equal mode, latch 0: one interrupt per line.
        wr(3'b100, 8'd0); wr(3'b101, 8'd0);
        line(); chk("R4", 1'b0);
        line(); chk("R6", 1'b0);
        wr(3'b110, 8'd0); wr(3'b111, 8'd0);
        line(); chk("R4", 1'b0);
        wr(3'b110, 8'd0); wr(3'b111, 8'd0);

        // Decrement-to-zero mode, latch 0: single shot, one more per reload write.
        alt_mode = 1'b1;
        wr(3'b101, 8'd0);
        line(); chk("R5", 1'b0);
        wr(3'b110, 8'd0); wr(3'b111, 8'd0);
        line(); chk("R5", 1'b1);
        line(); chk("R5", 1'b1);
        wr(3'b101, 8'd0);
        line(); chk("R5", 1'b0);
        wr(3'b110, 8'd0); wr(3'b111, 8'd0);

        // Decrement-to-zero mode, latch 3.
        wr(3'b100, 8'd3); wr(3'b101, 8'd0);
        line(); line(); line();
        chk("R5", 1'b1);
        line(); chk("R5", 1'b0);
        step(40); chk("R6", 1'b0);
        wr(3'b110, 8'd0); wr(3'b111, 8'd0); step(10);
        chk("R8", 1'b1);

        // Reload write restarts the count.
        alt_mode = 1'b0;
        wr(3'b100, 8'd2); wr(3'b101, 8'd0);
        line(); line();
        wr(3'b101, 8'd0);
        line(); chk("R10", 1'b1);
        line(); chk("R10", 1'b1);
        line(); chk("R10", 1'b0);
        wr(3'b110, 8'd0);

        // Ignored selects and a dropped strobe must not disturb the count (count is 0).
        wr(3'b111, 8'd0);
        wr(3'b001, 8'd9); wr(3'b011, 8'd9);
        wr_sel = 3'b101; step(1); wr_sel = 3'b000;
        line(); chk("R10", 1'b1);
        line(); chk("R10", 1'b1);
        line(); chk("R10", 1'b0);
        wr(3'b110, 8'd0);

        // Disabled: the count keeps moving, no interrupt.
        wr(3'b100, 8'd1); wr(3'b101, 8'd0);
        line(); line();
        chk("R9", 1'b1);
        wr(3'b111, 8'd0);
        line(); chk("R9", 1'b1);
        line(); chk("R9", 1'b0);
        wr(3'b110, 8'd0); wr(3'b111, 8'd0);

        // Collision: a disable write in the firing cycle wins.
        line();
        a12_in = 1'b1; step(2);
        wr(3'b110, 8'd0);
        chk("R11", 1'b1);
        a12_in = 1'b0; step(4);
        chk("R11", 1'b1);

        // Collision: an enable write in the firing cycle is too late.
        line();
        a12_in = 1'b1; step(2);
        wr(3'b111, 8'd0);
        chk("R11", 1'b1);
        a12_in = 1'b0; step(4);
        chk("R11", 1'b1);

        // Random phase: compared against the model every cycle.
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 3) == 0) a12_in = ~a12_in;
            if ($urandom_range(0, 199) == 0) alt_mode = ~alt_mode;
            if ($urandom_range(0, 7) == 0) begin
                wr_en = 1'b1;
                wr_sel = 3'($urandom_range(0, 7));
                wr_data = 8'($urandom_range(0, 4));
            end else begin
                wr_en = 1'($urandom_range(0, 15) == 0);
                wr_sel = 3'($urandom_range(0, 3));
                wr_data = 8'($urandom_range(0, 255));
            end
            step(1);
        end
        wr_en = 1'b0;
        step(2);
        summary();
    end
endmodule